// File: doc/BRIEF.md
# DMA Physical Address and Count Generator

This block serves one active DMA channel. Once the channel's start values are loaded, it forms the physical byte address for every transfer cycle and tracks how many transfers remain. The start values are a 16-bit address register, a 16-bit count, an 8-bit page, an 8-bit high page with a valid flag, and the channel width (byte or word). Each pulse on the step input moves the channel on by one transfer. When the last transfer is accepted, the block raises a one-cycle terminal-count pulse. It then ignores further steps until the next load.

The page mapping depends on the width. A byte channel places the page above a 16-bit byte address, in 64 KiB pages. A word channel shifts the 16-bit address up by one bit and uses only the upper seven page bits, in 128 KiB pages. The loaded count is one less than the number of transfers.

With no valid high page, the address register wraps inside its page and the upper byte of the address is zero, so the channel reaches only the lower 16 MiB. With a valid high page, a wrap of the address register carries into the page and high page.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is held and after it is released, phys_addr, count_rd and tc are all zero. Step pulses before the first load change none of them.
- R2: A load captures all channel values. From the cycle after the load edge, count_rd shows ld_count and phys_addr shows the mapped start address.
- R3: A byte channel (ld_word=0) gives phys_addr[23:16]=page and phys_addr[15:0]=address register.
- R4: A word channel (ld_word=1) gives phys_addr[16:1]=address register, phys_addr[23:17]=page[7:1] and phys_addr[0]=0. Page bit 0 has no effect.
- R5: An accepted step adds one to the address register and subtracts one from count_rd. Both are visible in the cycle after the step edge.
- R6: tc is high for exactly one cycle, the cycle after a step is accepted with count_rd at 0x0000. count_rd then reads 0xFFFF.
- R7: After terminal count, step pulses leave phys_addr and count_rd unchanged and raise no tc until the next load.
- R8: With ld_hipage_vld=0, phys_addr[31:24] is zero. A step from address 0xFFFF wraps the address register to 0x0000 and leaves the page unchanged.
- R9: With ld_hipage_vld=1 on a byte channel, phys_addr[31:24]=high page. A wrap of the address register adds one to the 16-bit {high page, page} value.
- R10: With ld_hipage_vld=1 on a word channel, a wrap of the address register adds one to the 15-bit {high page, page[7:1]} value, so the address moves to the next 128 KiB page.
- R11: When load and step are both high in the same cycle, the load wins and the step is dropped.
- R12: A loaded count of 0xFFFF allows 65536 transfers. tc follows the 65536th step and no earlier step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load | input | 1 | Captures the ld_* values as the channel's new start state |
| ld_addr | input | 16 | Start value of the address register |
| ld_count | input | 16 | Number of transfers minus one |
| ld_page | input | 8 | Page value |
| ld_hipage | input | 8 | High-page value (physical bits 31:24) |
| ld_hipage_vld | input | 1 | High page written; enables carry across the address wrap |
| ld_word | input | 1 | 1 = word channel, 0 = byte channel |
| step | input | 1 | One transfer done; advance address and count |
| phys_addr | output | 32 | Physical byte address of the current transfer |
| tc | output | 1 | Terminal-count pulse |
| count_rd | output | 16 | Current count readback |

## Verification
Every result comes from a register, so phys_addr, count_rd and tc respond in the cycle after the edge that took a load or step. None of them depends combinationally on an input. Reset release passes through a two-stage synchronizer, so the bench waits several cycles before its first stimulus.

The driver sets inputs at the falling edge and pushes the expected state at the same time. The monitor pops and compares 2 ns after the next rising edge. Each expected item is therefore checked in exactly the cycle its edge makes it due. The expected values come from a model of the physical byte address:
- Without a high page, it adds 1 or 2 inside a 16-bit or 17-bit field.
- With a high page, it adds across the full 32 bits.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_width_e;
endpackage

// File: rtl/dmag_rst_sync.sv
module dmag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/dmag_count.sv
module dmag_count #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_count,
  input  logic          step,
  output logic [CW-1:0] count_q,
  output logic          tc_q,
  output logic          accept
);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);
  localparam logic [CW-1:0] CNT_ZERO = '0;

  logic          done_q, done_d;
  logic [CW-1:0] count_d;
  logic          tc_d;
  logic          cnt_en;

  // a step is taken only while the channel is live and no load competes
  assign accept = step & ~done_q & ~load;
  assign cnt_en = load | accept;

  always_comb begin
    count_d = count_q;
    done_d  = done_q;
    tc_d    = 1'b0;
    if (load) begin
      count_d = ld_count;
      done_d  = 1'b0;
    end else if (accept) begin
      count_d = count_q - CNT_ONE;
      if (count_q == CNT_ZERO) begin
        tc_d   = 1'b1;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      done_q  <= 1'b1;
      tc_q    <= 1'b0;
    end else begin
      if (cnt_en) count_q <= count_d;
      if (cnt_en) done_q  <= done_d;
      tc_q <= tc_d;
    end
  end

  a_r2_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count_q == $past(ld_count));
  a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !done_q) |=> count_q == $past(count_q) - CNT_ONE);
  a_r6_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |-> ($past(accept) && $past(count_q) == CNT_ZERO));
  a_r6_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q |=> !tc_q);
  a_r7_hold_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !load) |=> ($stable(count_q) && !tc_q));
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load && step) |=> (count_q == $past(ld_count) && !tc_q));
endmodule

// File: rtl/dmag_addr.sv
module dmag_addr
  import dmag_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [PW-1:0] ld_page,
  input  logic [HW-1:0] ld_hipage,
  input  logic          ld_hipage_vld,
  input  xfer_width_e   ld_width,
  input  logic          accept,
  output logic [AW-1:0] addr_q,
  output logic [PW-1:0] page_q,
  output logic [HW-1:0] hipage_q,
  output logic          hpen_q,
  output xfer_width_e   width_q
);
  localparam int        BPW      = HW + PW;
  localparam int        WPW      = HW + PW - 1;
  localparam logic [AW-1:0] ADDR_MAX = '1;

  logic [AW-1:0]  addr_d;
  logic [PW-1:0]  page_d;
  logic [HW-1:0]  hipage_d;
  logic [BPW-1:0] byte_pg_inc;
  logic [WPW-1:0] word_pg_inc;
  logic           wrap;
  logic           addr_en;

  assign wrap        = (addr_q == ADDR_MAX);
  assign byte_pg_inc = {hipage_q, page_q} + BPW'(1);
  assign word_pg_inc = {hipage_q, page_q[PW-1:1]} + WPW'(1);
  assign addr_en     = load | accept;

  always_comb begin
    addr_d   = addr_q;
    page_d   = page_q;
    hipage_d = hipage_q;
    if (load) begin
      addr_d   = ld_addr;
      page_d   = ld_page;
      hipage_d = ld_hipage;
    end else if (accept) begin
      addr_d = addr_q + AW'(1);
      if (wrap && hpen_q) begin
        if (width_q == XFER_WORD) {hipage_d, page_d} = {word_pg_inc, page_q[0]};
        else                      {hipage_d, page_d} = byte_pg_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      page_q   <= '0;
      hipage_q <= '0;
      hpen_q   <= 1'b0;
      width_q  <= XFER_BYTE;
    end else begin
      if (addr_en) begin
        addr_q   <= addr_d;
        page_q   <= page_d;
        hipage_q <= hipage_d;
      end
      if (load) begin
        hpen_q  <= ld_hipage_vld;
        width_q <= ld_width;
      end
    end
  end

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> addr_q == $past(addr_q) + AW'(1));
  a_r8_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hpen_q) |=> ($stable(page_q) && $stable(hipage_q)));
  a_r9_byte_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hpen_q && wrap && width_q == XFER_BYTE)
      |=> {hipage_q, page_q} == $past({hipage_q, page_q}) + BPW'(1));
  a_r10_word_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && hpen_q && wrap && width_q == XFER_WORD)
      |=> {hipage_q, page_q[PW-1:1]} == $past({hipage_q, page_q[PW-1:1]}) + WPW'(1));
endmodule

// File: rtl/dmag_map.sv
module dmag_map
  import dmag_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8,
  parameter int HW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr_q,
  input  logic [PW-1:0]      page_q,
  input  logic [HW-1:0]      hipage_q,
  input  logic               hpen_q,
  input  xfer_width_e        width_q,
  output logic [HW+PW+AW-1:0] phys
);
  logic [HW-1:0] top_bits;

  // without a written high page the address stays below the page span
  assign top_bits = hpen_q ? hipage_q : '0;

  always_comb begin
    if (width_q == XFER_WORD) phys = {top_bits, page_q[PW-1:1], addr_q, 1'b0};
    else                      phys = {top_bits, page_q, addr_q};
  end

  a_r4_word_even: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q == XFER_WORD) |-> !phys[0]);
  a_r8_low_space: assert property (@(posedge clk) disable iff (!rst_n)
    !hpen_q |-> phys[HW+PW+AW-1:PW+AW] == '0);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dmag_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int PW = 8,
  parameter int HW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [AW-1:0]      ld_addr,
  input  logic [CW-1:0]      ld_count,
  input  logic [PW-1:0]      ld_page,
  input  logic [HW-1:0]      ld_hipage,
  input  logic               ld_hipage_vld,
  input  logic               ld_word,
  input  logic               step,
  output logic [HW+PW+AW-1:0] phys_addr,
  output logic               tc,
  output logic [CW-1:0]      count_rd
);
  logic          rst_n_s;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic [PW-1:0] page_q;
  logic [HW-1:0] hipage_q;
  logic          hpen_q;
  xfer_width_e   width_q;
  xfer_width_e   ld_width;

  assign ld_width = ld_word ? XFER_WORD : XFER_BYTE;

  dmag_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  dmag_count #(.CW(CW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load),
    .ld_count (ld_count),
    .step     (step),
    .count_q  (count_rd),
    .tc_q     (tc),
    .accept   (accept)
  );

  dmag_addr #(.AW(AW), .PW(PW), .HW(HW)) u_addr (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .load          (load),
    .ld_addr       (ld_addr),
    .ld_page       (ld_page),
    .ld_hipage     (ld_hipage),
    .ld_hipage_vld (ld_hipage_vld),
    .ld_width      (ld_width),
    .accept        (accept),
    .addr_q        (addr_q),
    .page_q        (page_q),
    .hipage_q      (hipage_q),
    .hpen_q        (hpen_q),
    .width_q       (width_q)
  );

  dmag_map #(.AW(AW), .PW(PW), .HW(HW)) u_map (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr_q   (addr_q),
    .page_q   (page_q),
    .hipage_q (hipage_q),
    .hpen_q   (hpen_q),
    .width_q  (width_q),
    .phys     (phys_addr)
  );

  a_r1_quiet_before_load: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($past(!rst_n_s) && !load) |=> (count_rd == '0 && !tc));
endmodule

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;
  logic        clk;
  logic        rst_n;
  logic        load;
  logic [15:0] ld_addr;
  logic [15:0] ld_count;
  logic [7:0]  ld_page;
  logic [7:0]  ld_hipage;
  logic        ld_hipage_vld;
  logic        ld_word;
  logic        step;
  logic [31:0] phys_addr;
  logic        tc;
  logic [15:0] count_rd;

  typedef struct {
    logic [31:0] phys;
    logic [15:0] cnt;
    logic        tc;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   ended  = 0;

  logic [31:0] m_phys;
  logic [15:0] m_cnt;
  logic        m_tc, m_done, m_hp, m_word;

  dma_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr), .ld_count(ld_count),
    .ld_page(ld_page), .ld_hipage(ld_hipage), .ld_hipage_vld(ld_hipage_vld),
    .ld_word(ld_word), .step(step), .phys_addr(phys_addr), .tc(tc), .count_rd(count_rd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops one expected item per cycle, 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (phys_addr !== e.phys || count_rd !== e.cnt || tc !== e.tc) begin
        fails++;
        $display("FAIL %s: phys=%h cnt=%h tc=%b expected phys=%h cnt=%h tc=%b",
                 e.tag, phys_addr, count_rd, tc, e.phys, e.cnt, e.tc);
      end
    end
  end

  task automatic mdl_step();
    if (!m_done) begin
      m_tc = (m_cnt == 16'h0000);
      if (m_tc) m_done = 1'b1;
      m_cnt = m_cnt - 16'd1;
      if (m_word) begin
        if (m_hp) m_phys = m_phys + 32'd2;
        else      m_phys[16:0] = m_phys[16:0] + 17'd2;
      end else begin
        if (m_hp) m_phys = m_phys + 32'd1;
        else      m_phys[15:0] = m_phys[15:0] + 16'd1;
      end
    end else begin
      m_tc = 1'b0;
    end
  endtask

  task automatic cyc(input bit ld, input bit st, input logic [15:0] a, input logic [15:0] c,
                     input logic [7:0] p, input logic [7:0] h, input bit hv, input bit w,
                     input string tag);
    exp_t e;
    @(negedge clk);
    load = ld; step = st; ld_addr = a; ld_count = c; ld_page = p;
    ld_hipage = h; ld_hipage_vld = hv; ld_word = w;
    if (ld) begin
      logic [7:0] top;
      top = hv ? h : 8'h00;
      m_phys = w ? {top, p[7:1], a, 1'b0} : {top, p, a};
      m_cnt = c; m_done = 1'b0; m_tc = 1'b0; m_hp = hv; m_word = w;
    end else if (st) begin
      mdl_step();
    end else begin
      m_tc = 1'b0;
    end
    e.phys = m_phys; e.cnt = m_cnt; e.tc = m_tc; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                         input logic [7:0] h, input bit hv, input bit w, input string tag);
    cyc(1, 0, a, c, p, h, hv, w, tag);
  endtask

  task automatic do_steps(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 1, 16'h0, 16'h0, 8'h0, 8'h0, 0, 0, tag);
  endtask

  task automatic do_idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 16'h0, 16'h0, 8'h0, 8'h0, 0, 0, tag);
  endtask

  initial begin
    rst_n = 1'b0; load = 0; step = 0; ld_addr = '0; ld_count = '0;
    ld_page = '0; ld_hipage = '0; ld_hipage_vld = 0; ld_word = 0;
    m_phys = '0; m_cnt = '0; m_tc = 0; m_done = 1; m_hp = 0; m_word = 0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (phys_addr !== 32'h0 || count_rd !== 16'h0 || tc !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: phys=%h cnt=%h tc=%b expected 0/0/0", phys_addr, count_rd, tc);
    end
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    do_idle(2, "R1 idle after reset");
    do_steps(3, "R1 step before load ignored");

    do_load(16'h1234, 16'h0003, 8'h56, 8'hAB, 0, 0, "R2 R3 byte load");
    do_steps(3, "R5 byte step");
    do_steps(1, "R6 terminal count");
    do_idle(1, "R6 tc single pulse");
    do_steps(4, "R7 steps after tc ignored");

    do_load(16'hFFFE, 16'h0005, 8'h12, 8'hAB, 0, 0, "R8 byte no hipage load");
    do_steps(3, "R8 byte wrap in page");

    do_load(16'hFFFF, 16'h0010, 8'hFF, 8'hAB, 1, 0, "R9 byte hipage load");
    do_steps(2, "R9 byte carry into hipage");

    do_load(16'h8000, 16'h0004, 8'h35, 8'h00, 0, 1, "R4 word load page bit0 ignored");
    do_steps(2, "R4 word step by two bytes");

    do_load(16'hFFFF, 16'h0004, 8'h07, 8'h10, 0, 1, "R8 word no hipage load");
    do_steps(2, "R8 word wrap in 128K page");

    do_load(16'hFFFF, 16'h0004, 8'h07, 8'h10, 1, 1, "R10 word hipage load");
    do_steps(2, "R10 word carry to next 128K page");

    do_load(16'h0100, 16'h0002, 8'h20, 8'h00, 0, 0, "R11 base load");
    do_steps(1, "R11 step");
    cyc(1, 1, 16'h0A00, 16'h0009, 8'h44, 8'h00, 0, 0, "R11 load with step");
    do_idle(1, "R11 after load");

    do_load(16'h0000, 16'hFFFF, 8'h01, 8'h00, 0, 0, "R12 full count load");
    do_steps(65535, "R12 no early tc");
    do_steps(1, "R12 tc on last transfer");
    do_steps(2, "R12 R7 hold after tc");
    do_idle(3, "drain");

    wait (exp_q.size() == 0);
    @(posedge clk); #3;
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule